// File: doc/BRIEF.md
# Segmented Parallel-Prefix Carry-Select Adder

This block adds two unsigned N-bit operands and a carry input, returning an N-bit sum and a carry output. It is purely combinational. The operands are cut into equal segments of a parameterised width.

The lowest segment is a single parallel-prefix adder that takes the real carry input. Every higher segment holds two parallel-prefix adders that run side by side, one with carry-in tied to 0 and one tied to 1. The carry leaving the segment below then picks one of the two sums and carry-outs through a multiplexer.

Inside each prefix adder, every bit forms a generate (a AND b) and a propagate (a XOR b). A logarithmic-depth network of black and gray cells merges spans that double in length at each level. Each sum bit is the bit's propagate XOR the carry into that bit.

It suits a datapath that sits after partial-product accumulation. There it resolves a final sum and carry pair to binary within a fixed logic depth.

Top module: `ks_csel_adder`

## Requirements
- R1: For every input, {cout, sum} equals a + b + cin computed as an (N+1)-bit unsigned value.
- R2: With a all ones, b equal to 1 and cin 0, sum is all zeros and cout is 1.
- R3: With a and b both all ones and cin 1, sum is all ones and cout is 1.
- R4: With a and b both zero, sum equals cin in bit 0 with all other bits 0, and cout is 0.
- R5: A carry produced inside one segment reaches the next segment. With a holding ones in the lowest segment only and b = 1, sum is 2 to the power of the segment width and cout is 0.
- R6: When a and b are bitwise complements of each other, sum is all ones with cout 0 for cin 0, and sum is all zeros with cout 1 for cin 1.
- R7: Exchanging a and b leaves sum and cout unchanged.
- R8: Alternating bit patterns (0101… and 1010…, in either operand order and with either carry input) give the arithmetic result of R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand, unsigned |
| b | input | WIDTH | Second operand, unsigned |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Low WIDTH bits of a + b + cin |
| cout | output | 1 | Carry out of the top bit |

## Verification
The bench builds two copies of the adder. The first uses the defaults, WIDTH 32 with SEG_W 8: four segments with a three-level prefix network, so carries have to cross three select multiplexers. The second uses WIDTH 12 with SEG_W 3. That segment width is not a power of two, so the prefix network has a partly filled top level. It also yields four short segments, which makes boundary-crossing carries frequent under both directed and random operands.

// File: rtl/ks_csel_pkg.sv
package ks_csel_pkg;

  // Merge of a high span with the adjacent lower span.
  function automatic logic grp_gen(input logic g_hi, input logic p_hi, input logic g_lo);
    return g_hi | (p_hi & g_lo);
  endfunction

  function automatic logic grp_prop(input logic p_hi, input logic p_lo);
    return p_hi & p_lo;
  endfunction

  function automatic int prefix_levels(input int w);
    return (w <= 1) ? 0 : $clog2(w);
  endfunction

endpackage

// File: rtl/ks_prefix_adder.sv
module ks_prefix_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  import ks_csel_pkg::*;

  localparam int LVLS = prefix_levels(W);

  logic [W-1:0]          bit_p;
  logic [LVLS:0][W-1:0]  gs;
  logic [LVLS:0][W-1:0]  ps;
  logic [W-1:0]          carry_in_bit;

  // Pre-processing; carry input folded into bit 0 generate
  always_comb begin
    bit_p = a ^ b;
    gs[0] = a & b;
    gs[0][0] = (a[0] & b[0]) | (bit_p[0] & cin);
    ps[0] = bit_p;
  end

  // Prefix network: level k joins bit i with bit i - 2^k
  for (genvar k = 0; k < LVLS; k++) begin : g_lvl
    localparam int D = 1 << k;
    for (genvar i = 0; i < W; i++) begin : g_bit
      if (i < D) begin : g_pass
        assign gs[k+1][i] = gs[k][i];
        assign ps[k+1][i] = ps[k][i];
      end else if (i < 2 * D) begin : g_gray
        // span now reaches bit 0: only group generate is needed further on
        assign gs[k+1][i] = grp_gen(gs[k][i], ps[k][i], gs[k][i-D]);
        assign ps[k+1][i] = 1'b0;
      end else begin : g_black
        assign gs[k+1][i] = grp_gen(gs[k][i], ps[k][i], gs[k][i-D]);
        assign ps[k+1][i] = grp_prop(ps[k][i], ps[k][i-D]);
      end
    end
  end

  // Post-processing
  always_comb begin
    carry_in_bit = {gs[LVLS][W-2:0], cin};
    sum  = bit_p ^ carry_in_bit;
    cout = gs[LVLS][W-1];
  end

endmodule

// File: rtl/ks_csel_segment.sv
module ks_csel_segment #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sel_cin,
  output logic [W-1:0] sum,
  output logic         cout
);

  logic [W-1:0] sum_c0, sum_c1;
  logic         co_c0, co_c1;

  ks_prefix_adder #(.W(W)) i_add_c0 (
    .a(a), .b(b), .cin(1'b0), .sum(sum_c0), .cout(co_c0)
  );

  ks_prefix_adder #(.W(W)) i_add_c1 (
    .a(a), .b(b), .cin(1'b1), .sum(sum_c1), .cout(co_c1)
  );

  always_comb begin
    if (sel_cin) begin
      sum  = sum_c1;
      cout = co_c1;
    end else begin
      sum  = sum_c0;
      cout = co_c0;
    end
  end

endmodule

// File: rtl/ks_csel_adder.sv
module ks_csel_adder #(
  parameter int WIDTH = 32,
  parameter int SEG_W = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);

  localparam int NSEG = WIDTH / SEG_W;

  logic [NSEG:0] seg_carry;

  assign seg_carry[0] = cin;

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    localparam int LO = s * SEG_W;
    if (s == 0) begin : g_base
      ks_prefix_adder #(.W(SEG_W)) i_base (
        .a(a[LO +: SEG_W]), .b(b[LO +: SEG_W]), .cin(seg_carry[s]),
        .sum(sum[LO +: SEG_W]), .cout(seg_carry[s+1])
      );
    end else begin : g_sel
      ks_csel_segment #(.W(SEG_W)) i_sel (
        .a(a[LO +: SEG_W]), .b(b[LO +: SEG_W]), .sel_cin(seg_carry[s]),
        .sum(sum[LO +: SEG_W]), .cout(seg_carry[s+1])
      );
    end
  end

  assign cout = seg_carry[NSEG];

endmodule

// File: rtl/ks_csel_adder_chk.sv
module ks_csel_adder_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic             cin,
  input logic [WIDTH-1:0] sum,
  input logic             cout
);

  logic [WIDTH:0] exp_full;

  always_comb begin
    exp_full = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
    AST_SUM_EXACT: assert ({cout, sum} == exp_full); // R1
    if (a == '0 && b == '0) begin
      AST_ZERO_OPS: assert (cout == 1'b0 && sum == {{(WIDTH-1){1'b0}}, cin}); // R4
    end
    if ((a ^ b) == '1 && (a & b) == '0) begin
      AST_COMPLEMENT: assert (cout == cin && sum == {WIDTH{~cin}}); // R6
    end
    if (a == '1 && b == '1 && cin) begin
      AST_ALL_ONES: assert (cout && sum == '1); // R3
    end
  end

endmodule

bind ks_csel_adder ks_csel_adder_chk #(.WIDTH(WIDTH)) i_chk (.*);

// File: tb/test_ks_csel_adder.sv
module test_ks_csel_adder;

  localparam int CLK_PERIOD = 10;
  localparam int WA = 32;
  localparam int SA = 8;
  localparam int WB = 12;
  localparam int SB = 3;

  logic clk;
  logic rst_n;
  int   checks;
  int   failures;

  logic [WA-1:0] a_a, b_a, s_a;
  logic          ci_a, co_a;
  logic [WB-1:0] a_b, b_b, s_b;
  logic          ci_b, co_b;

  ks_csel_adder #(.WIDTH(WA), .SEG_W(SA)) i_ks_csel_adder (
    .a(a_a), .b(b_a), .cin(ci_a), .sum(s_a), .cout(co_a)
  );

  ks_csel_adder #(.WIDTH(WB), .SEG_W(SB)) i_ks_csel_adder_odd (
    .a(a_b), .b(b_b), .cin(ci_b), .sum(s_b), .cout(co_b)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Drive on the falling edge, compare both widths against explicit expectations.
  task automatic apply_cmp(input logic [WA-1:0] x, input logic [WA-1:0] y, input logic c,
                           input logic [WA:0] exp_a, input logic [WB:0] exp_b,
                           input string req);
    @(negedge clk);
    a_a = x; b_a = y; ci_a = c;
    a_b = x[WB-1:0]; b_b = y[WB-1:0]; ci_b = c;
    #1;
    checks++;
    if ({co_a, s_a} !== exp_a) begin
      failures++;
      $display("FAIL %s w32: a=%h b=%h cin=%b actual=%h expected=%h", req, x, y, c, {co_a, s_a}, exp_a);
    end
    checks++;
    if ({co_b, s_b} !== exp_b) begin
      failures++;
      $display("FAIL %s w12: a=%h b=%h cin=%b actual=%h expected=%h", req, x[WB-1:0], y[WB-1:0], c, {co_b, s_b}, exp_b);
    end
  endtask

  task automatic apply_arith(input logic [WA-1:0] x, input logic [WA-1:0] y, input logic c,
                             input string req);
    logic [WA:0] ea;
    logic [WB:0] eb;
    ea = {1'b0, x} + {1'b0, y} + {{WA{1'b0}}, c};
    eb = {1'b0, x[WB-1:0]} + {1'b0, y[WB-1:0]} + {{WB{1'b0}}, c};
    apply_cmp(x, y, c, ea, eb, req);
  endtask

  task automatic t_reset_state;
    // R4: zero operands after reset
    apply_cmp('0, '0, 1'b0, '0, '0, "R4");
    apply_cmp('0, '0, 1'b1, {{WA{1'b0}}, 1'b1}, {{WB{1'b0}}, 1'b1}, "R4");
  endtask

  task automatic t_all_ones_plus_one;
    // R2: all ones + 1 -> zero sum, carry out set
    apply_cmp('1, {{(WA-1){1'b0}}, 1'b1}, 1'b0, {1'b1, {WA{1'b0}}}, {1'b1, {WB{1'b0}}}, "R2");
  endtask

  task automatic t_all_ones_cin;
    // R3: all ones + all ones + 1 -> all ones sum, carry out set
    apply_cmp('1, '1, 1'b1, {1'b1, {WA{1'b1}}}, {1'b1, {WB{1'b1}}}, "R3");
  endtask

  task automatic t_segment_cross;
    logic [WA-1:0] xa;
    // R5: low segment full of ones plus one ripples into segment 1
    xa = '0;
    xa[SA-1:0] = '1;
    apply_cmp(xa, 32'd1, 1'b0, 33'd1 << SA,
              ({1'b0, {(WB-SA){1'b0}}, {SA{1'b1}}} + 13'd1), "R5");
    apply_cmp({{(WA-SB){1'b0}}, {SB{1'b1}}}, 32'd1, 1'b0,
              33'd1 << SB, 13'd1 << SB, "R5");
    apply_cmp({{(WA-SB){1'b0}}, {SB{1'b1}}}, '0, 1'b1, 33'd1 << SB, 13'd1 << SB, "R5");
  endtask

  task automatic t_complement;
    // R6: complementary operands
    apply_cmp(32'h1234_abcd, ~32'h1234_abcd, 1'b0, {1'b0, {WA{1'b1}}}, {1'b0, {WB{1'b1}}}, "R6");
    apply_cmp(32'h1234_abcd, ~32'h1234_abcd, 1'b1, {1'b1, {WA{1'b0}}}, {1'b1, {WB{1'b0}}}, "R6");
  endtask

  task automatic t_alternating;
    // R8: 0101... and 1010... in both orders with both carry inputs
    for (int c = 0; c < 2; c++) begin
      apply_arith(32'h5555_5555, 32'hAAAA_AAAA, c[0], "R8");
      apply_arith(32'hAAAA_AAAA, 32'h5555_5555, c[0], "R8");
      apply_arith(32'h5555_5555, 32'h5555_5555, c[0], "R8");
      apply_arith(32'hAAAA_AAAA, 32'hAAAA_AAAA, c[0], "R8");
    end
  endtask

  task automatic t_swap;
    logic [WA:0] r1_a;
    logic [WB:0] r1_b;
    // R7: swapped operands give the same result as the first order
    for (int n = 0; n < 40; n++) begin
      logic [WA-1:0] x, y;
      logic c;
      x = $urandom; y = $urandom; c = $urandom_range(0, 1);
      @(negedge clk);
      a_a = x; b_a = y; ci_a = c; a_b = x[WB-1:0]; b_b = y[WB-1:0]; ci_b = c;
      #1;
      r1_a = {co_a, s_a};
      r1_b = {co_b, s_b};
      apply_cmp(y, x, c, r1_a, r1_b, "R7");
    end
  endtask

  task automatic t_random;
    // R1: random operands against the arithmetic sum
    for (int n = 0; n < 400; n++) begin
      logic [WA-1:0] x, y;
      x = $urandom; y = $urandom;
      if (n % 8 == 0) x = x | 32'h00FF_FF00;
      if (n % 8 == 1) y = ~x;
      apply_arith(x, y, n[1], "R1");
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks = 0;
    failures = 0;
    rst_n = 1'b0;
    a_a = '0; b_a = '0; ci_a = 1'b0;
    a_b = '0; b_b = '0; ci_b = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_all_ones_plus_one();
    t_all_ones_cin();
    t_segment_cross();
    t_complement();
    t_alternating();
    t_swap();
    t_random();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule